// File: doc/BRIEF.md
# Predicated compare result writer

This block turns integer compare outcomes into predicate bits. It has a set of compare lanes that run in parallel. Each lane compares two 64-bit operands under one of four relations and gets a single boolean result. The lane then applies one of five update rules to two target predicates in a 64-entry file of one-bit registers. The rules are normal, unconditional, AND, OR and DeMorgan. A qualifying predicate, also read from the same file, gates every update.

Lanes that fire in the same cycle form one group. All qualifying predicate reads in a group see the file as it was before the group. All updates of the group land together on the next clock edge. The parallel rules (AND, OR, DeMorgan) write only one polarity, so several lanes may aim at one predicate and merge. The usual pattern builds a multi-term OR condition: one compare that is always false clears the target, and a group of OR lanes then sets it if any term holds. Independent read ports expose the file so that later instructions can be qualified.

Top module: `pred_cmp_writer`

## Requirements
- R1: Predicate 0 always reads as 1 on every read port, and writes aimed at index 0 are dropped.
- R2: After reset, every predicate other than index 0 reads 0.
- R3: Relation codes are 0 = equal, 1 = not-equal, 2 = signed less-than and 3 = unsigned less-than, on the two 64-bit operands.
- R4: Type code 0 (normal): when the qualifying predicate is 1, the first target takes the result and the second target takes its complement. Otherwise neither target changes.
- R5: Type code 1 (unconditional): when the qualifying predicate is 0, both targets are cleared. Otherwise it behaves as normal.
- R6: Type code 2 (AND): when the lane is qualified and the result is 0, both targets are cleared. Otherwise nothing changes.
- R7: Type code 3 (OR): when the lane is qualified and the result is 1, both targets are set. Otherwise nothing changes. Several OR lanes may target the same predicate in one cycle.
- R8: Type code 4 (DeMorgan): when the lane is qualified and the result is 1, the first target is set and the second is cleared. Otherwise nothing changes.
- R9: Each lane reads its qualifying predicate from the file state before the current cycle's updates. Updates become visible on the read ports one clock edge after the lane is presented.
- R10: When several writes hit one predicate in the same cycle, the higher-numbered lane wins. Within a lane, the second target wins over the first.
- R11: A lane whose valid bit is low, or whose type code is 5 to 7, changes no predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_valid_i | input | LANES | Per-lane compare valid |
| lane_type_i | input | 3*LANES | Per-lane update rule code |
| lane_rel_i | input | 2*LANES | Per-lane relation code |
| lane_qp_i | input | 6*LANES | Per-lane qualifying predicate index |
| lane_t1_i | input | 6*LANES | Per-lane first target index |
| lane_t2_i | input | 6*LANES | Per-lane second target index |
| lane_a_i | input | 64*LANES | Per-lane first operand |
| lane_b_i | input | 64*LANES | Per-lane second operand |
| rd_idx_i | input | 6*RD_PORTS | Read port predicate indices |
| rd_val_o | output | RD_PORTS | Read port predicate values |

## Verification
The bench builds the block with three lanes and two read ports. With three lanes, a three-term OR accumulation fits in one cycle. It also lets an OR lane and an AND lane collide on one predicate with a lane between them, which exercises the lane-priority merge. The second read port checks predicate 0 on a separate path during reset. The scoreboard covers signed and unsigned ordering with a negative operand, reads of the qualifying predicate from the previous state within a group, and targets of index 0.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  typedef enum logic [2:0] {
    CT_NORMAL   = 3'd0,
    CT_UNC      = 3'd1,
    CT_AND      = 3'd2,
    CT_OR       = 3'd3,
    CT_DEMORGAN = 3'd4
  } cmp_type_e;

  typedef enum logic [1:0] {
    REL_EQ  = 2'd0,
    REL_NE  = 2'd1,
    REL_LT  = 2'd2,
    REL_LTU = 2'd3
  } cmp_rel_e;

  typedef struct packed {
    logic we1;
    logic d1;
    logic we2;
    logic d2;
  } pred_wr_t;
endpackage

// File: rtl/pcw_cmp_eval.sv
module pcw_cmp_eval #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    rel_i,
  output logic          res_o
);
  import pcw_pkg::*;

  logic eq_w, slt_w, ult_w;

  assign eq_w  = (a_i == b_i);
  assign ult_w = (a_i < b_i);
  assign slt_w = ($signed(a_i) < $signed(b_i));

  always_comb begin
    unique case (cmp_rel_e'(rel_i))
      REL_EQ:  res_o = eq_w;
      REL_NE:  res_o = !eq_w;
      REL_LT:  res_o = slt_w;
      REL_LTU: res_o = ult_w;
      default: res_o = 1'b0;
    endcase
  end

  // equal sign bits: signed and unsigned ordering agree
  always_comb begin
    if (a_i[DW-1] == b_i[DW-1])
      a_r3_sign_agree: assert (slt_w == ult_w);
  end
endmodule

// File: rtl/pcw_rule.sv
module pcw_rule (
  input  logic                 valid_i,
  input  logic [2:0]           type_i,
  input  logic                 qp_i,
  input  logic                 res_i,
  output pcw_pkg::pred_wr_t    wr_o
);
  import pcw_pkg::*;

  always_comb begin
    wr_o = '0;
    if (valid_i) begin
      case (type_i)
        CT_NORMAL: if (qp_i) wr_o = '{we1: 1'b1, d1: res_i, we2: 1'b1, d2: !res_i};
        CT_UNC: begin
          if (qp_i) wr_o = '{we1: 1'b1, d1: res_i, we2: 1'b1, d2: !res_i};
          else      wr_o = '{we1: 1'b1, d1: 1'b0, we2: 1'b1, d2: 1'b0};
        end
        CT_AND:      if (qp_i && !res_i) wr_o = '{we1: 1'b1, d1: 1'b0, we2: 1'b1, d2: 1'b0};
        CT_OR:       if (qp_i && res_i)  wr_o = '{we1: 1'b1, d1: 1'b1, we2: 1'b1, d2: 1'b1};
        CT_DEMORGAN: if (qp_i && res_i)  wr_o = '{we1: 1'b1, d1: 1'b1, we2: 1'b1, d2: 1'b0};
        default:     wr_o = '0;
      endcase
    end
  end

  always_comb begin
    if (type_i == CT_AND)
      a_r6_and_clears_only: assert (!(wr_o.we1 && wr_o.d1) && !(wr_o.we2 && wr_o.d2));
    if (type_i == CT_OR)
      a_r7_or_sets_only: assert (!(wr_o.we1 && !wr_o.d1) && !(wr_o.we2 && !wr_o.d2));
    if (!valid_i || type_i > 3'd4)
      a_r11_idle_quiet: assert (!wr_o.we1 && !wr_o.we2);
    if (valid_i && !qp_i && type_i != CT_UNC)
      a_r4_unqualified_quiet: assert (!wr_o.we1 && !wr_o.we2);
  end
endmodule

// File: rtl/pcw_pred_file.sv
module pcw_pred_file #(
  parameter int unsigned NPRED    = 64,
  parameter int unsigned LANES    = 2,
  parameter int unsigned RD_PORTS = 2,
  localparam int unsigned IW      = $clog2(NPRED)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  pcw_pkg::pred_wr_t       wr_i   [LANES],
  input  logic [LANES*IW-1:0]     t1_i,
  input  logic [LANES*IW-1:0]     t2_i,
  input  logic [LANES*IW-1:0]     qp_idx_i,
  output logic [LANES-1:0]        qp_val_o,
  input  logic [RD_PORTS*IW-1:0]  rd_idx_i,
  output logic [RD_PORTS-1:0]     rd_val_o
);
  logic [NPRED-1:1] pred_q, pred_d, hit_w;

  function automatic logic rd_pred(input logic [NPRED-1:1] f, input logic [IW-1:0] idx);
    if (idx == '0) return 1'b1;
    return f[idx];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_qp
    assign qp_val_o[l] = rd_pred(pred_q, qp_idx_i[l*IW +: IW]);
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    assign rd_val_o[r] = rd_pred(pred_q, rd_idx_i[r*IW +: IW]);
    always_comb begin
      if (rd_idx_i[r*IW +: IW] == '0)
        a_r1_p0_reads_one: assert (rd_val_o[r] == 1'b1);
    end
  end

  // later lanes, then second target, override earlier writes
  always_comb begin
    pred_d = pred_q;
    for (int l = 0; l < LANES; l++) begin
      if (wr_i[l].we1 && t1_i[l*IW +: IW] != '0) pred_d[t1_i[l*IW +: IW]] = wr_i[l].d1;
      if (wr_i[l].we2 && t2_i[l*IW +: IW] != '0) pred_d[t2_i[l*IW +: IW]] = wr_i[l].d2;
    end
  end

  always_comb begin
    hit_w = '0;
    for (int i = 1; i < NPRED; i++)
      for (int l = 0; l < LANES; l++)
        hit_w[i] = hit_w[i]
                 | (wr_i[l].we1 && t1_i[l*IW +: IW] == IW'(i))
                 | (wr_i[l].we2 && t2_i[l*IW +: IW] == IW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pred_q <= '0;
    else         pred_q <= pred_d;
  end

  for (genvar i = 1; i < NPRED; i++) begin : g_hold
    a_r11_untouched_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_w[i] |=> pred_q[i] == $past(pred_q[i]));
  end
endmodule

// File: rtl/pred_cmp_writer.sv
module pred_cmp_writer #(
  parameter int unsigned LANES    = 2,
  parameter int unsigned RD_PORTS = 2,
  parameter int unsigned NPRED    = 64,
  parameter int unsigned DW       = 64,
  localparam int unsigned IW      = $clog2(NPRED)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES-1:0]        lane_valid_i,
  input  logic [LANES*3-1:0]      lane_type_i,
  input  logic [LANES*2-1:0]      lane_rel_i,
  input  logic [LANES*IW-1:0]     lane_qp_i,
  input  logic [LANES*IW-1:0]     lane_t1_i,
  input  logic [LANES*IW-1:0]     lane_t2_i,
  input  logic [LANES*DW-1:0]     lane_a_i,
  input  logic [LANES*DW-1:0]     lane_b_i,
  input  logic [RD_PORTS*IW-1:0]  rd_idx_i,
  output logic [RD_PORTS-1:0]     rd_val_o
);
  import pcw_pkg::*;

  pred_wr_t         wr_w  [LANES];
  logic [LANES-1:0] qp_w;
  logic [LANES-1:0] res_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pcw_cmp_eval #(.DW(DW)) u_eval (
      .a_i   (lane_a_i[l*DW +: DW]),
      .b_i   (lane_b_i[l*DW +: DW]),
      .rel_i (lane_rel_i[l*2 +: 2]),
      .res_o (res_w[l])
    );

    pcw_rule u_rule (
      .valid_i (lane_valid_i[l]),
      .type_i  (lane_type_i[l*3 +: 3]),
      .qp_i    (qp_w[l]),
      .res_i   (res_w[l]),
      .wr_o    (wr_w[l])
    );
  end

  pcw_pred_file #(.NPRED(NPRED), .LANES(LANES), .RD_PORTS(RD_PORTS)) u_file (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_w),
    .t1_i     (lane_t1_i),
    .t2_i     (lane_t2_i),
    .qp_idx_i (lane_qp_i),
    .qp_val_o (qp_w),
    .rd_idx_i (rd_idx_i),
    .rd_val_o (rd_val_o)
  );
endmodule

// File: tb/pred_cmp_writer_tb_top.sv
module pred_cmp_writer_tb_top;
  localparam int L = 3;
  localparam int R = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [L-1:0]    valid = '0;
  logic [L*3-1:0]  typ = '0;
  logic [L*2-1:0]  rel = '0;
  logic [L*6-1:0]  qp = '0, t1 = '0, t2 = '0;
  logic [L*64-1:0] a = '0, b = '0;
  logic [R*6-1:0]  rd_idx = '0;
  logic [R-1:0]    rd_val;

  pred_cmp_writer #(.LANES(L), .RD_PORTS(R)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lane_valid_i(valid), .lane_type_i(typ),
    .lane_rel_i(rel), .lane_qp_i(qp), .lane_t1_i(t1), .lane_t2_i(t2),
    .lane_a_i(a), .lane_b_i(b), .rd_idx_i(rd_idx), .rd_val_o(rd_val));

  typedef struct { int idx; bit val; string tag; } exp_t;
  exp_t sb_q[$];
  bit   model [64];
  int   checks = 0, errors = 0;
  bit   done = 0;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic expect_p(int idx, string tag);
    exp_t e;
    e.idx = idx; e.val = model[idx]; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic set_lane(int l, int ty, int rl, int q, int p1, int p2,
                          logic [63:0] av, logic [63:0] bv);
    valid[l] = 1'b1; typ[l*3 +: 3] = 3'(ty); rel[l*2 +: 2] = 2'(rl);
    qp[l*6 +: 6] = 6'(q); t1[l*6 +: 6] = 6'(p1); t2[l*6 +: 6] = 6'(p2);
    a[l*64 +: 64] = av; b[l*64 +: 64] = bv;
  endtask

  function automatic bit eval_rel(int rl, logic [63:0] av, logic [63:0] bv);
    case (rl)
      0: return av == bv;
      1: return av != bv;
      2: return $signed(av) < $signed(bv);
      default: return av < bv;
    endcase
  endfunction

  function automatic void model_step();
    bit old [64];
    old = model;
    for (int l = 0; l < L; l++) begin
      bit w1 = 0, w2 = 0, d1 = 0, d2 = 0;
      bit q = old[qp[l*6 +: 6]];
      bit r = eval_rel(int'(rel[l*2 +: 2]), a[l*64 +: 64], b[l*64 +: 64]);
      if (valid[l]) begin
        case (int'(typ[l*3 +: 3]))
          0: if (q) begin w1 = 1; w2 = 1; d1 = r; d2 = !r; end
          1: begin w1 = 1; w2 = 1; if (q) begin d1 = r; d2 = !r; end end
          2: if (q && !r) begin w1 = 1; w2 = 1; end
          3: if (q && r) begin w1 = 1; w2 = 1; d1 = 1; d2 = 1; end
          4: if (q && r) begin w1 = 1; w2 = 1; d1 = 1; end
          default: ;
        endcase
      end
      if (w1 && t1[l*6 +: 6] != 0) model[t1[l*6 +: 6]] = d1;
      if (w2 && t2[l*6 +: 6] != 0) model[t2[l*6 +: 6]] = d2;
    end
  endfunction

  // driver: present one group, update model after the edge, queue expectations
  task automatic issue();
    @(posedge clk);
    model_step();
    #1;
    valid = '0;
  endtask

  task automatic sync();
    wait (sb_q.size() == 0);
    #2;
    @(negedge clk);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        rd_idx[0 +: 6] = 6'(e.idx);
        #1;
        checks++;
        if (rd_val[0] !== e.val) begin
          errors++;
          $display("FAIL %s: p%0d actual %0b expected %0b", e.tag, e.idx, rd_val[0], e.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    rd_idx[6 +: 6] = 6'd0;
    #3;
    checks++;
    if (rd_val[1] !== 1'b1) begin
      errors++;
      $display("FAIL R1: p0 in reset actual %0b expected 1", rd_val[1]);
    end
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // R2 reset state, R1 predicate 0
    sync(); expect_p(0, "R1"); expect_p(5, "R2"); expect_p(63, "R2");

    // R4 normal, R3 equal / not-equal
    sync();
    set_lane(0, 0, 0, 0, 2, 3, 64'd7, 64'd7);
    set_lane(1, 0, 1, 0, 4, 5, 64'd7, 64'd7);
    issue(); expect_p(2, "R4"); expect_p(3, "R4"); expect_p(4, "R3"); expect_p(5, "R3");

    // R4 unqualified normal (qp=9 is 0) changes nothing
    sync();
    set_lane(0, 0, 0, 9, 5, 2, 64'd1, 64'd2);
    issue(); expect_p(5, "R4"); expect_p(2, "R4");

    // R5 unconditional, R3 signed vs unsigned
    sync();
    set_lane(0, 1, 0, 9, 2, 5, 64'd1, 64'd1);
    set_lane(1, 1, 2, 0, 6, 7, NEG1, 64'd1);
    set_lane(2, 1, 3, 0, 8, 11, NEG1, 64'd1);
    issue(); expect_p(2, "R5"); expect_p(5, "R5");
    expect_p(6, "R3"); expect_p(7, "R3"); expect_p(8, "R3"); expect_p(11, "R3");

    // R7 OR accumulation: clear, all-false terms, then one true term
    sync();
    set_lane(0, 0, 1, 0, 10, 12, 64'd3, 64'd3);
    issue(); expect_p(10, "R7"); expect_p(12, "R7");
    sync();
    set_lane(0, 3, 0, 0, 10, 13, 64'd1, 64'd2);
    set_lane(1, 3, 0, 0, 10, 13, 64'd3, 64'd4);
    set_lane(2, 3, 0, 0, 10, 13, 64'd5, 64'd6);
    issue(); expect_p(10, "R7"); expect_p(13, "R7");
    sync();
    set_lane(0, 3, 0, 0, 10, 13, 64'd1, 64'd2);
    set_lane(1, 3, 0, 0, 10, 13, 64'd4, 64'd4);
    set_lane(2, 3, 0, 0, 10, 13, 64'd5, 64'd6);
    issue(); expect_p(10, "R7"); expect_p(13, "R7");

    // R6 AND: true terms hold, a false term clears
    sync();
    set_lane(0, 2, 0, 0, 10, 13, 64'd9, 64'd9);
    set_lane(1, 2, 1, 0, 10, 13, 64'd1, 64'd9);
    issue(); expect_p(10, "R6"); expect_p(13, "R6");
    sync();
    set_lane(0, 2, 0, 0, 10, 13, 64'd9, 64'd9);
    set_lane(1, 2, 0, 0, 10, 13, 64'd1, 64'd9);
    issue(); expect_p(10, "R6"); expect_p(13, "R6");

    // R8 DeMorgan
    sync();
    set_lane(0, 0, 0, 0, 16, 17, 64'd1, 64'd1);
    issue();
    sync();
    set_lane(0, 4, 2, 0, 15, 16, NEG1, 64'd0);
    issue(); expect_p(15, "R8"); expect_p(16, "R8");
    sync();
    set_lane(0, 0, 0, 0, 18, 19, 64'd1, 64'd1);
    set_lane(1, 4, 0, 0, 18, 19, 64'd1, 64'd2);
    issue(); expect_p(18, "R8"); expect_p(19, "R8");

    // R1 writes to predicate 0 dropped
    sync();
    set_lane(0, 1, 0, 9, 0, 0, 64'd0, 64'd0);
    set_lane(1, 0, 1, 0, 0, 0, 64'd5, 64'd5);
    issue(); expect_p(0, "R1");

    // R10 lane priority and second-target priority
    sync();
    set_lane(0, 3, 0, 0, 20, 21, 64'd1, 64'd1);
    set_lane(1, 0, 0, 0, 23, 23, 64'd1, 64'd1);
    set_lane(2, 2, 0, 0, 20, 22, 64'd1, 64'd2);
    issue(); expect_p(20, "R10"); expect_p(21, "R10"); expect_p(22, "R10"); expect_p(23, "R10");

    // R11 reserved types and invalid lanes
    sync();
    set_lane(0, 5, 0, 0, 2, 21, 64'd1, 64'd1);
    set_lane(1, 7, 0, 0, 2, 21, 64'd1, 64'd1);
    set_lane(2, 0, 0, 0, 2, 21, 64'd1, 64'd1);
    valid[2] = 1'b0;
    issue(); expect_p(2, "R11"); expect_p(21, "R11");

    // R9 qualifying predicate sampled before same-group update
    sync();
    set_lane(0, 0, 0, 0, 30, 31, 64'd1, 64'd1);
    set_lane(1, 0, 0, 30, 32, 33, 64'd1, 64'd1);
    issue(); expect_p(30, "R9"); expect_p(32, "R9"); expect_p(33, "R9");
    sync();
    set_lane(0, 0, 0, 30, 32, 33, 64'd1, 64'd1);
    issue(); expect_p(32, "R9"); expect_p(33, "R9");

    sync();
    report();
  end
endmodule